// File: doc/BRIEF.md
# Six-Channel Single-Line Serial Audio Receiver

This block accepts PCM audio from an external source that supplies its own bit clock, left/right clock and one serial data line. The block runs on a local system clock, synchronizes the three serial inputs and treats each rising bit-clock edge it detects as one bit time. Two packed formats carry three mono words back to back in each half of the left/right period. One packs 20-bit words at 128 bit clocks per frame. The other packs 24-bit words at 256 bit clocks per frame. A third, conventional format carries one right-justified 18-bit word per half at 64 bit clocks per frame.

Once a frame has been received, all six words are presented together on one parallel bus, left-aligned in their fields, with a one-cycle valid strobe. A frame whose halves do not have the bit-clock count of the selected format is reported with an error strobe instead, and the previous words are held. The format is chosen by a static select input that only changes while the block is in reset.

Top module: `olr_rx`

## Requirements
- R1: After reset, `pcm_words` is all zero and neither `frame_valid` nor `frame_err` is asserted until a frame completes.
- R2: With `fmt_sel` = 2'b01, each half is 64 bit clocks and carries three 20-bit words sent MSB first. Each word appears in its 24-bit field with its MSB at bit 23 and the low 4 bits zero.
- R3: With `fmt_sel` = 2'b10, each half is 128 bit clocks and carries three 24-bit words sent MSB first, filling the whole 24-bit field.
- R4: The half in which the left/right clock is high fills fields 0, 1, 2 (bits 23:0, 47:24, 71:48) in arrival order. The low half fills fields 3, 4, 5 (bits 95:72 and up) in arrival order.
- R5: In the packed formats, data-line values on bit clocks after the third word of a half do not change any output word.
- R6: With `fmt_sel` = 2'b00, each half is 32 bit clocks. The 18-bit word ends with its LSB on the last bit clock before the left/right transition. The high-half word goes to field 0 and the low-half word to field 3, both with the MSB at bit 23 of the field. Fields 1, 2, 4 and 5 read zero.
- R7: Counting the first rising bit-clock edge that sees a new left/right level as position 0, the first MSB of a packed half is taken at position 1. The value at position 0 is ignored.
- R8: A frame is a high half followed by a low half. It completes on the next rising left/right transition. All six fields then update in the same cycle that `frame_valid` is high for exactly one cycle. Otherwise `pcm_words` holds.
- R9: If either half of a frame has a bit-clock count that differs from the selected format, `frame_err` pulses for one cycle instead of `frame_valid`, and `pcm_words` keeps the last good frame. A later correct frame is again accepted.
- R10: With `fmt_sel` = 2'b11 (unused), no frame is ever valid and each completed frame pulses `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Format select: 00 right-justified 18-bit, 01 packed 20-bit, 10 packed 24-bit, 11 unused |
| bclk_in | input | 1 | Serial bit clock from the source |
| lrck_in | input | 1 | Left/right frame clock from the source, high for the first half |
| sdata_in | input | 1 | Serial data line |
| pcm_words | output | 6*SAMPLE_W | Six sample fields, field 0 in the low bits |
| frame_valid | output | 1 | One-cycle strobe when a good frame is loaded |
| frame_err | output | 1 | One-cycle strobe when a frame fails its length check |

## Verification
On every cycle, the assertions check these invariants: the valid strobe lasts one cycle, valid and error never coincide, the words hold between strobes, the unused format never yields a valid frame, and the unused fields read zero whenever a right-justified frame loads. Only the directed scenarios can show that bits land in the right field and bit position, that idle and position-0 bits are skipped, and that short or long halves are rejected and followed by recovery. Those scenarios compare the loaded words against values computed from the serial patterns that the bench itself sends.

// File: rtl/olr_pkg.sv
package olr_pkg;

  typedef enum logic [1:0] {
    FMT_RJ18  = 2'b00,
    FMT_PK20  = 2'b01,
    FMT_PK24  = 2'b10,
    FMT_UNUSED = 2'b11
  } fmt_e;

  localparam int RJ_WORD_W = 18;
  localparam int NUM_CH    = 6;
  localparam int CH_PER_HALF = 3;

  // bit clocks in one half of the left/right period; 0 marks no valid length
  function automatic int half_len(input fmt_e f);
    case (f)
      FMT_RJ18: half_len = 32;
      FMT_PK20: half_len = 64;
      FMT_PK24: half_len = 128;
      default:  half_len = 0;
    endcase
  endfunction

  function automatic int word_len(input fmt_e f);
    case (f)
      FMT_RJ18: word_len = RJ_WORD_W;
      FMT_PK20: word_len = 20;
      FMT_PK24: word_len = 24;
      default:  word_len = 0;
    endcase
  endfunction

endpackage

// File: rtl/olr_in_sync.sv
module olr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrck_in,
  input  logic sdata_in,
  output logic bit_stb,
  output logic lr_lvl,
  output logic sd_bit
);

  // stage word layout: {bclk, lrck, sdata}
  logic [2:0] stg_q [STAGES];
  logic       bclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= {bclk_in, lrck_in, sdata_in};
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '0;
      else        stg_q[k] <= stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= stg_q[STAGES-1][2];
  end

  assign bit_stb = stg_q[STAGES-1][2] & ~bclk_prev_q;
  assign lr_lvl  = stg_q[STAGES-1][1];
  assign sd_bit  = stg_q[STAGES-1][0];

endmodule

// File: rtl/olr_slot_capture.sv
module olr_slot_capture
  import olr_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  fmt_e                       fmt,
  input  logic                       bit_stb,
  input  logic                       lr_lvl,
  input  logic                       sd_bit,
  output logic                       half_done,
  output logic                       new_lr,
  output logic                       len_ok,
  output logic                       synced,
  output logic [NUM_CH*SAMPLE_W-1:0] slot_bus
);

  localparam int BIT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             lr_q, lr_d;
  logic [CNT_W-1:0] pos_q, pos_d, pos_inc;
  logic [1:0]       slot_q, slot_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             synced_q, synced_d;
  logic             lr_chg, cap;
  logic [2:0]       cap_ch;
  logic             packed_fmt;
  int               hl, wl;

  logic [SAMPLE_W-1:0] sh_q [NUM_CH];

  always_comb begin
    hl         = half_len(fmt);
    wl         = word_len(fmt);
    packed_fmt = (fmt == FMT_PK20) || (fmt == FMT_PK24);
    lr_chg     = bit_stb && (lr_lvl != lr_q);
    pos_inc    = (pos_q == CNT_MAX) ? pos_q : pos_q + 1'b1;
  end

  // next state of the position, slot and bit counters
  always_comb begin
    lr_d     = lr_q;
    pos_d    = pos_q;
    slot_d   = slot_q;
    bit_d    = bit_q;
    synced_d = synced_q;
    cap      = 1'b0;
    cap_ch   = '0;
    if (bit_stb) begin
      lr_d = lr_lvl;
      if (lr_chg) begin
        pos_d    = '0;
        slot_d   = '0;
        bit_d    = '0;
        synced_d = 1'b1;
      end else begin
        pos_d = pos_inc;
        if (packed_fmt) begin
          if (slot_q < 2'(CH_PER_HALF)) begin
            cap    = 1'b1;
            cap_ch = (lr_lvl ? 3'd0 : 3'd3) + {1'b0, slot_q};
            if (bit_q == BIT_W'(wl - 1)) begin
              bit_d  = '0;
              slot_d = slot_q + 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end else if (fmt == FMT_RJ18) begin
          if ((int'(pos_inc) >= hl - RJ_WORD_W) && (int'(pos_inc) <= hl - 1)) begin
            cap    = 1'b1;
            cap_ch = lr_lvl ? 3'd0 : 3'd3;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q     <= 1'b0;
      pos_q    <= '0;
      slot_q   <= '0;
      bit_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      lr_q     <= lr_d;
      pos_q    <= pos_d;
      slot_q   <= slot_d;
      bit_q    <= bit_d;
      synced_q <= synced_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic shift_en;
    assign shift_en = cap && (cap_ch == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q[g] <= '0;
      else if (shift_en) sh_q[g] <= {sh_q[g][SAMPLE_W-2:0], sd_bit};
    end
    assign slot_bus[g*SAMPLE_W +: SAMPLE_W] = sh_q[g];
  end

  assign half_done = lr_chg;
  assign new_lr    = lr_lvl;
  assign len_ok    = (hl != 0) && (int'(pos_q) == hl - 1);
  assign synced    = synced_q;

endmodule

// File: rtl/olr_frame_out.sv
module olr_frame_out
  import olr_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  fmt_e                       fmt,
  input  logic                       half_done,
  input  logic                       new_lr,
  input  logic                       len_ok,
  input  logic                       synced,
  input  logic [NUM_CH*SAMPLE_W-1:0] slot_bus,
  output logic [NUM_CH*SAMPLE_W-1:0] pcm_words,
  output logic                       frame_valid,
  output logic                       frame_err
);

  logic [NUM_CH*SAMPLE_W-1:0] aligned, words_q, words_d;
  logic left_ok_q, left_ok_d;
  logic valid_q, valid_d, err_q, err_d;

  // left-align each captured word in its field
  for (genvar g = 0; g < NUM_CH; g++) begin : g_align
    logic [SAMPLE_W-1:0] raw;
    assign raw = slot_bus[g*SAMPLE_W +: SAMPLE_W];
    always_comb begin
      case (fmt)
        FMT_PK20: aligned[g*SAMPLE_W +: SAMPLE_W] = raw << (SAMPLE_W - 20);
        FMT_PK24: aligned[g*SAMPLE_W +: SAMPLE_W] = raw << (SAMPLE_W - 24);
        FMT_RJ18: aligned[g*SAMPLE_W +: SAMPLE_W] =
                    (g == 0 || g == CH_PER_HALF) ? raw << (SAMPLE_W - RJ_WORD_W) : '0;
        default:  aligned[g*SAMPLE_W +: SAMPLE_W] = '0;
      endcase
    end
  end

  always_comb begin
    left_ok_d = left_ok_q;
    words_d   = words_q;
    valid_d   = 1'b0;
    err_d     = 1'b0;
    if (half_done) begin
      if (!new_lr) begin
        left_ok_d = synced && len_ok;
      end else if (synced) begin
        left_ok_d = 1'b0;
        if (left_ok_q && len_ok) begin
          valid_d = 1'b1;
          words_d = aligned;
        end else begin
          err_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_ok_q <= 1'b0;
      words_q   <= '0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      left_ok_q <= left_ok_d;
      words_q   <= words_d;
      valid_q   <= valid_d;
      err_q     <= err_d;
    end
  end

  assign pcm_words   = words_q;
  assign frame_valid = valid_q;
  assign frame_err   = err_q;

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_hold_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(pcm_words));

  assert_valid_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && frame_err));

  assert_unused_never_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_UNUSED) |-> !frame_valid);

  assert_rj_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && fmt == FMT_RJ18) |->
      (pcm_words[1*SAMPLE_W +: 2*SAMPLE_W] == '0) &&
      (pcm_words[4*SAMPLE_W +: 2*SAMPLE_W] == '0));

endmodule

// File: rtl/olr_rx.sv
module olr_rx
  import olr_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 fmt_sel,
  input  logic                       bclk_in,
  input  logic                       lrck_in,
  input  logic                       sdata_in,
  output logic [NUM_CH*SAMPLE_W-1:0] pcm_words,
  output logic                       frame_valid,
  output logic                       frame_err
);

  logic rst_meta_q, rst_int_n;
  logic bit_stb, lr_lvl, sd_bit;
  logic half_done, new_lr, len_ok, synced;
  logic [NUM_CH*SAMPLE_W-1:0] slot_bus;
  fmt_e fmt;

  assign fmt = fmt_e'(fmt_sel);

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  olr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bclk_in  (bclk_in),
    .lrck_in  (lrck_in),
    .sdata_in (sdata_in),
    .bit_stb  (bit_stb),
    .lr_lvl   (lr_lvl),
    .sd_bit   (sd_bit)
  );

  olr_slot_capture #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fmt       (fmt),
    .bit_stb   (bit_stb),
    .lr_lvl    (lr_lvl),
    .sd_bit    (sd_bit),
    .half_done (half_done),
    .new_lr    (new_lr),
    .len_ok    (len_ok),
    .synced    (synced),
    .slot_bus  (slot_bus)
  );

  olr_frame_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fmt         (fmt),
    .half_done   (half_done),
    .new_lr      (new_lr),
    .len_ok      (len_ok),
    .synced      (synced),
    .slot_bus    (slot_bus),
    .pcm_words   (pcm_words),
    .frame_valid (frame_valid),
    .frame_err   (frame_err)
  );

endmodule

// File: tb/olr_rx_tb.sv
`timescale 1ns/1ps
module olr_rx_tb;

  localparam int SW = 24;
  localparam int WB = 6 * SW;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] fmt_sel;
  logic bclk, lrck, sdata;
  logic [WB-1:0] pcm_words;
  logic frame_valid, frame_err;

  int checks = 0, errors = 0;
  int vcnt = 0, ecnt = 0;
  logic [WB-1:0] cap_words = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  olr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .bclk_in(bclk), .lrck_in(lrck), .sdata_in(sdata),
    .pcm_words(pcm_words), .frame_valid(frame_valid), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid) begin vcnt++; cap_words = pcm_words; end
      if (frame_err) ecnt++;
    end
  end

  task automatic chk(input string tag, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic lv, input logic d);
    @(negedge clk);
    lrck = lv; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  // rj=1: right-justified 18-bit word w0; else three packed words of wl bits
  task automatic send_half(input logic lv, input int len, input int wl, input bit rj,
                           input logic [3*SW-1:0] trio);
    for (int i = 0; i < len; i++) begin
      logic d;
      d = 1'b1;
      if (rj) begin
        if (i >= len - 18) d = trio[17 - (i - (len - 18))];
      end else if (i >= 1 && i <= 3 * wl) begin
        d = trio[((i - 1) / wl) * SW + (wl - 1 - ((i - 1) % wl))];
      end
      bit_out(lv, d);
    end
  endtask

  task automatic do_reset(input logic [1:0] f);
    rst_n = 1'b0; fmt_sel = f; bclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    vcnt = 0; ecnt = 0;
  endtask

  function automatic logic [WB-1:0] pk_exp(input logic [3*SW-1:0] l, input logic [3*SW-1:0] r,
                                           input int wl);
    logic [WB-1:0] e;
    for (int s = 0; s < 3; s++) begin
      logic [SW-1:0] m;
      m = (SW'(1) << wl) - 1;
      e[s*SW +: SW]     = (l[s*SW +: SW] & m) << (SW - wl);
      e[(s+3)*SW +: SW] = (r[s*SW +: SW] & m) << (SW - wl);
    end
    return e;
  endfunction

  task automatic t_reset();
    do_reset(2'b01);
    chk("R1 words after reset", pcm_words, '0);
    chk("R1 valid after reset", WB'(frame_valid), '0);
    chk("R1 err after reset", WB'(frame_err), '0);
    repeat (50) @(negedge clk);
    chk("R1 no strobe while idle", WB'(vcnt + ecnt), '0);
  endtask

  task automatic t_packed(input logic [1:0] f, input int wl, input int hl, input string tag);
    logic [3*SW-1:0] l1, r1, l2, r2;
    l1 = {24'h13579B, 24'h2468AC, 24'hF0F0F0};
    r1 = {24'h0F0F0F, 24'hA5A5A5, 24'h5A5A5A};
    l2 = {24'h00F00D, 24'hC0FFEE, 24'h8BEEF1};
    r2 = {24'h7D0C3A, 24'h000001, 24'hFFFFFF};
    do_reset(f);
    send_half(1'b0, 3, wl, 1'b0, '0);
    send_half(1'b1, hl, wl, 1'b0, l1);
    send_half(1'b0, hl, wl, 1'b0, r1);
    send_half(1'b1, hl, wl, 1'b0, l2);
    repeat (20) @(negedge clk);
    chk({tag, " R4 R5 R7 first frame"}, cap_words, pk_exp(l1, r1, wl));
    send_half(1'b0, hl, wl, 1'b0, r2);
    send_half(1'b1, 1, wl, 1'b0, '0);
    repeat (20) @(negedge clk);
    chk({tag, " R4 R5 R7 second frame"}, cap_words, pk_exp(l2, r2, wl));
    chk({tag, " R8 two valid strobes"}, WB'(vcnt), WB'(2));
    chk({tag, " R8 no error strobes"}, WB'(ecnt), '0);
    repeat (40) @(negedge clk);
    chk({tag, " R8 words hold"}, pcm_words, pk_exp(l2, r2, wl));
  endtask

  task automatic t_rj();
    logic [WB-1:0] e;
    logic [17:0] lw, rw;
    lw = 18'h2A5C3; rw = 18'h1F00F;
    do_reset(2'b00);
    send_half(1'b0, 3, 0, 1'b1, '0);
    send_half(1'b1, 32, 0, 1'b1, {48'h0, 6'h0, lw});
    send_half(1'b0, 32, 0, 1'b1, {48'h0, 6'h0, rw});
    send_half(1'b1, 1, 0, 1'b1, '0);
    repeat (20) @(negedge clk);
    e = '0;
    e[0 +: SW]    = {lw, 6'h0};
    e[3*SW +: SW] = {rw, 6'h0};
    chk("R6 right-justified words", cap_words, e);
    chk("R6 one valid strobe", WB'(vcnt), WB'(1));
    chk("R6 no error", WB'(ecnt), '0);
  endtask

  task automatic t_frame_err();
    logic [3*SW-1:0] a, b;
    a = {24'h111111, 24'h222222, 24'h333333};
    b = {24'h444444, 24'h555555, 24'h666666};
    do_reset(2'b01);
    send_half(1'b0, 3, 20, 1'b0, '0);
    send_half(1'b1, 64, 20, 1'b0, a);
    send_half(1'b0, 64, 20, 1'b0, a);
    send_half(1'b1, 64, 20, 1'b0, b);
    send_half(1'b0, 63, 20, 1'b0, b);
    send_half(1'b1, 65, 20, 1'b0, b);
    repeat (20) @(negedge clk);
    chk("R9 short half flagged", WB'(ecnt), WB'(1));
    chk("R9 words kept after error", pcm_words, pk_exp(a, a, 20));
    send_half(1'b0, 64, 20, 1'b0, b);
    send_half(1'b1, 64, 20, 1'b0, b);
    send_half(1'b0, 64, 20, 1'b0, b);
    send_half(1'b1, 1, 20, 1'b0, '0);
    repeat (20) @(negedge clk);
    chk("R9 long half flagged", WB'(ecnt), WB'(2));
    chk("R9 recovery loads frame", cap_words, pk_exp(b, b, 20));
    chk("R9 valid count", WB'(vcnt), WB'(2));
  endtask

  task automatic t_unused();
    logic [3*SW-1:0] a;
    a = {24'hABCDEF, 24'h123456, 24'h789ABC};
    do_reset(2'b11);
    send_half(1'b0, 3, 20, 1'b0, '0);
    for (int k = 0; k < 2; k++) begin
      send_half(1'b1, 64, 20, 1'b0, a);
      send_half(1'b0, 64, 20, 1'b0, a);
    end
    send_half(1'b1, 1, 20, 1'b0, '0);
    repeat (20) @(negedge clk);
    chk("R10 never valid", WB'(vcnt), '0);
    chk("R10 error per frame", WB'(ecnt), WB'(2));
    chk("R10 words untouched", pcm_words, '0);
  endtask

  initial begin
    t_reset();
    t_packed(2'b01, 20, 64, "R2");
    t_packed(2'b10, 24, 128, "R3");
    t_rj();
    t_frame_err();
    t_unused();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule